// File: doc/BRIEF.md
# Debounced Pushbutton Decade Display Counter

This block counts presses of a mechanical pushbutton from 0 to 9 and drives a seven-segment display with the current digit. The raw switch is asynchronous to the system clock and may bounce. The block first passes it through a flip-flop synchronizer. A stability counter then accepts a press only after the switch has stayed at its pressed level, logic 1, for a set number of consecutive clocks. Each accepted press produces a single one-clock pulse, and that pulse advances a wrapping decade counter. The counter value is decoded to segment lines.

The switch never clocks anything. Everything runs on one clock, with an active-low asynchronous reset. The qualification length is a parameter, so it can be matched to the clock frequency and the bounce time of the button. A button held down indefinitely counts once. Another step needs the switch to be seen released first.

Top module: `press_decade_display`

## Requirements
- R1: After reset the segment output is 1111110, the digit 0, where bit 6 is segment a and bit 0 is segment g, active high.
- R2: With a clean press, the display changes on exactly the rising edge SYNC_STAGES + HOLD_CYCLES + 1 after the first edge that samples the switch high, and not one edge earlier (SYNC_STAGES is at least 2).
- R3: A press held for HOLD_CYCLES - 1 clock samples does not change the display, and one held for HOLD_CYCLES samples advances it by one.
- R4: Any released sample restarts qualification, so a burst of short high pulses separated by low samples, each shorter than HOLD_CYCLES, causes no count.
- R5: A switch held pressed for many times HOLD_CYCLES advances the count only once, and the internal press pulse never lasts more than one clock.
- R6: Each accepted press raises the digit by one, and the digit wraps from 9 back to 0.
- R7: The digits 1 to 9 show 0110000, 1101101, 1111001, 0110011, 1011011, 1011111, 1110000, 1111111 and 1111011 in that order, with the same bit order as R1. A count code above 9 shows the pattern for 0.
- R8: Asserting reset in the middle of operation returns the display to 0 at once, and counting starts again from 0 after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Raw pushbutton level, 1 = pressed, asynchronous and possibly bouncing |
| seg_out | output | 7 | Segment lines a (bit 6) to g (bit 0), active high |

## Verification
The bench goes after the qualification boundary. A press one sample short of the threshold must leave the display unchanged, and a press exactly at the threshold must count. A design that is off by one in the threshold compare fails one of these two cases. Bursts of bounce pulses catch a counter that accumulates across releases instead of restarting. A long hold catches a qualifier that keeps pulsing once it has saturated. The exact-latency probe, the full walk through the ten patterns with the 9-to-0 wrap, and a reset issued mid-count catch wrong pipeline depth, wrong segment patterns and state that survives reset.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
   localparam int SEG_W     = 7;
   localparam int DIGIT_W   = 4;
   typedef logic [SEG_W-1:0]   seg_t;
   typedef logic [DIGIT_W-1:0] digit_t;
   localparam digit_t DIGIT_TOP = digit_t'(9);

   // bit 6 = segment a ... bit 0 = segment g, active high
   function automatic seg_t digit_to_seg(input digit_t d);
      seg_t s;
      case (d)
         4'd1:    s = 7'b0110000;
         4'd2:    s = 7'b1101101;
         4'd3:    s = 7'b1111001;
         4'd4:    s = 7'b0110011;
         4'd5:    s = 7'b1011011;
         4'd6:    s = 7'b1011111;
         4'd7:    s = 7'b1110000;
         4'd8:    s = 7'b1111111;
         4'd9:    s = 7'b1111011;
         default: s = 7'b1111110;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/pdd_sync.sv
module pdd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pdd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/pdd_qualify.sv
module pdd_qualify #(
   parameter int HOLD_CYCLES = 100,
   localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          level,
   output logic [CW-1:0] stab_cnt,
   output logic          press
);
   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("pdd_qualify: HOLD_CYCLES must be at least 2");
   end

   localparam logic [CW-1:0] LIMIT   = CW'(HOLD_CYCLES);
   localparam logic [CW-1:0] PRE_LIM = CW'(HOLD_CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stab_cnt <= '0;
         press    <= 1'b0;
      end else begin
         press <= level && (stab_cnt == PRE_LIM);
         if (!level)                stab_cnt <= '0;
         else if (stab_cnt != LIMIT) stab_cnt <= stab_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pdd_decade.sv
module pdd_decade
   import pdd_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   step,
   output digit_t digit,
   output seg_t   seg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   digit <= '0;
      else if (step) begin
         if (digit >= DIGIT_TOP)    digit <= '0;
         else                       digit <= digit + 1'b1;
      end
   end

   always_comb seg = digit_to_seg(digit);
endmodule

// File: rtl/press_decade_display.sv
module press_decade_display
   import pdd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 100,
   localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             btn_raw,
   output logic [SEG_W-1:0] seg_out
);
   logic          btn_sync;
   logic [CW-1:0] stab_cnt;
   logic          press_pulse;
   digit_t        digit;

   pdd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(btn_raw), .dout(btn_sync)
   );

   pdd_qualify #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
      .clk(clk), .rst_n(rst_n), .level(btn_sync),
      .stab_cnt(stab_cnt), .press(press_pulse)
   );

   pdd_decade u_dec (
      .clk(clk), .rst_n(rst_n), .step(press_pulse),
      .digit(digit), .seg(seg_out)
   );
endmodule

// File: rtl/pdd_checker.sv
module pdd_checker #(
   parameter int HOLD_CYCLES = 100,
   localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          btn_sync,
   input logic [CW-1:0] stab_cnt,
   input logic          press_pulse,
   input logic [3:0]    digit
);
   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      press_pulse |=> !press_pulse);

   assert_release_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !btn_sync |=> (stab_cnt == '0));

   assert_stab_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stab_cnt <= CW'(HOLD_CYCLES));

   assert_digit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      digit <= 4'd9);

   assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (press_pulse && digit < 4'd9) |=> (digit == $past(digit) + 4'd1));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (press_pulse && digit == 4'd9) |=> (digit == 4'd0));

   assert_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !press_pulse |=> $stable(digit));
endmodule

bind press_decade_display pdd_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .btn_sync(btn_sync), .stab_cnt(stab_cnt),
   .press_pulse(press_pulse), .digit(digit)
);

// File: tb/sim_press_decade_display.sv
module sim_press_decade_display;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 8;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       btn = 1'b0;
   logic [6:0] seg;

   int n_cmp = 0;
   int n_bad = 0;
   int exp_cnt = 0;
   bit done = 1'b0;

   typedef struct {
      logic [6:0] seg;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   press_decade_display #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .btn_raw(btn), .seg_out(seg)
   );

   function automatic logic [6:0] pat(input int d);
      case (d)
         0: return 7'b1111110;
         1: return 7'b0110000;
         2: return 7'b1101101;
         3: return 7'b1111001;
         4: return 7'b0110011;
         5: return 7'b1011011;
         6: return 7'b1011111;
         7: return 7'b1110000;
         8: return 7'b1111111;
         default: return 7'b1111011;
      endcase
   endfunction

   task automatic compare(input logic [6:0] act, input logic [6:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: seg actual %b expected %b", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard items away from the active edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         compare(seg, e.seg, e.tag);
      end
   end

   task automatic expect_digit(input string tag);
      @(posedge clk);
      q.push_back('{seg: pat(exp_cnt), tag: tag});
      @(negedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      btn = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // switch high for exactly n rising edges
   task automatic press(input int n);
      @(negedge clk);
      btn = 1'b1;
      repeat (n) @(negedge clk);
      btn = 1'b0;
   endtask

   task automatic good_press();
      press(HOLD);
      idle(6);
      exp_cnt = (exp_cnt + 1) % 10;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_digit("R1 reset digit");

      // R3: one sample short
      press(HOLD - 1);
      idle(6);
      expect_digit("R3 short press rejected");
      // R3: exactly the threshold
      good_press();
      expect_digit("R3 threshold press counted");

      // R4: bounce bursts
      for (int k = 0; k < 4; k++) begin
         press(HOLD - 2);
         idle(1);
      end
      idle(6);
      expect_digit("R4 bounce burst ignored");
      good_press();
      expect_digit("R4 press after bounce");

      // R5: long hold counts once
      press(4 * HOLD);
      idle(6);
      exp_cnt = (exp_cnt + 1) % 10;
      expect_digit("R5 long hold single step");

      // R2: exact latency
      @(negedge clk);
      btn = 1'b1;
      repeat (SYNC + HOLD) @(negedge clk);
      compare(seg, pat(exp_cnt), "R2 no change one edge early");
      @(negedge clk);
      exp_cnt = (exp_cnt + 1) % 10;
      compare(seg, pat(exp_cnt), "R2 change on expected edge");
      idle(6);

      // R7 / R6: walk all digits and wrap
      for (int k = 0; k < 7; k++) begin
         good_press();
         if (exp_cnt == 0) expect_digit("R6 wrap 9 to 0");
         else              expect_digit("R7 digit pattern");
      end
      good_press();
      expect_digit("R6 step after wrap");

      // R8: reset mid-operation
      good_press();
      @(negedge clk);
      rst_n = 1'b0;
      exp_cnt = 0;
      #1;
      compare(seg, pat(0), "R8 reset clears display");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      good_press();
      expect_digit("R8 counting restarts");

      idle(4);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule